// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical address by reading a tree of translation tables held in memory. A root register gives the physical base of the top table for the running address space. The walker cuts the virtual page number into equal index fields, one per level. The top field picks an entry in the root table. Each entry found above the bottom level points to the next table down. The bottom entry names the physical frame. The page offset is carried into the result untouched. Translation runs in the forward direction only.

A client hands in one virtual address at a time on a valid/ready request channel and collects the outcome on a valid/ready response channel. The outcome is either a physical address or a page fault that names the level where the walk stopped. The walker fetches entries through a read port that allows one read in flight at a time. The number of levels (2 to 5), the index width, the offset width and the physical address width are all parameters. Software changes the root register through a write port that only takes effect between walks.

Top module: `ptw_walker`

## Requirements
- R1: After reset, rsp_valid and mem_req_valid are 0, req_ready and root_ready are 1, and the root register holds 0.
- R2: The first read of a walk goes to root + 8 × (top index field), where the top field is vaddr bits [OFF_W+(LEVELS-1)·IDX_W +: IDX_W].
- R3: Level k (0 = top) uses vaddr bits [OFF_W+(LEVELS-1-k)·IDX_W +: IDX_W]. Its read address is the base taken from the previous entry plus 8 × that field. The base is entry bits [PA_W-1:OFF_W] with OFF_W zero bits appended. A walk with no fault makes exactly LEVELS reads, from the top level down, and waits for each response before it issues the next read.
- R4: A walk with no fault answers rsp_fault = 0, rsp_level = LEVELS-1 and rsp_paddr = {last entry bits [PA_W-1:OFF_W], vaddr[OFF_W-1:0]}.
- R5: If the entry read at level k has bit 0 (valid) clear, the walk ends with rsp_fault = 1, rsp_level = k and rsp_paddr = 0, and no further read is issued.
- R6: A read request, once raised, keeps its address stable until it is accepted. No new read is raised while a response is still owed.
- R7: A root write is taken only when root_ready is 1, which means the walker is idle. During a walk, root_ready is 0 and the root register keeps its value, so a held write is applied after the walk completes.
- R8: The response stays valid with stable contents until rsp_ready is seen.
- R9: req_ready is 0 during a walk and in any idle cycle where root_we is 1, so a root write always goes in before a request in the same cycle.
- R10: Entry bits other than bit 0 and bits [PA_W-1:OFF_W] have no effect on the read addresses or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_we | input | 1 | Root register write strobe |
| root_wdata | input | PA_W | New root table base |
| root_ready | output | 1 | Walker idle; root write accepted |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted |
| req_vaddr | input | LEVELS·IDX_W+OFF_W | Virtual address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_level | output | $clog2(LEVELS) | Level of the last entry read |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The bench builds the walker with three levels, 3-bit index fields, a 6-bit offset and a 15-bit physical space. This makes every table exactly one page long, so the whole 4096-entry memory can be modelled in the bench. With that memory, random entries often chain into faults at every depth, and read addresses land anywhere in the space. The memory model adds random acceptance delay and response latency, so the single-read ordering and the request hold are exercised. Directed cases cover faults at the top and bottom levels, a walk straight after reset with a zero root, a root write held through a busy walk, and a root write raised in the same cycle as a request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W         = 64;
  localparam int ENTRY_SHIFT     = 3;
  localparam int ENTRY_VALID_BIT = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_REQ,
    S_WAIT,
    S_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vaddr[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < LEVELS; g++) begin
      if (lvl == LVL_W'(g)) idx = slice[g];
    end
  end

  logic unused_off;
  assign unused_off = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:0]    base,
  input  logic [IDX_W-1:0]   idx,
  input  logic [ENTRY_W-1:0] entry,
  output logic [PA_W-1:0]    entry_addr,
  output logic [PA_W-1:0]    next_base,
  output logic               entry_valid
);
  assign entry_addr  = base + (PA_W'(idx) << ENTRY_SHIFT);
  assign next_base   = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign entry_valid = entry[ENTRY_VALID_BIT];

  logic unused_bits;
  assign unused_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:1]};
endmodule

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PA_W-1:0] wdata,
  input  logic            idle,
  output logic [PA_W-1:0] root_q
);
  always_ff @(posedge clk) begin
    if (rst)              root_q <= '0;
    else if (we && idle)  root_q <= wdata;
  end

  // R7: the root cannot move while a walk is running
  a_r7_root_frozen: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(root_q));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 40,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               root_we,
  input  logic [PA_W-1:0]    root_wdata,
  output logic               root_ready,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  walk_state_e      state;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  root_q;
  logic [IDX_W-1:0] cur_idx;
  logic [PA_W-1:0]  entry_addr;
  logic [PA_W-1:0]  next_base;
  logic             entry_valid;
  logic             idle;

  assign idle       = (state == S_IDLE);
  assign root_ready = idle;
  assign req_ready  = idle && !root_we;

  ptw_root_reg #(.PA_W(PA_W)) i_root (
    .clk(clk), .rst(rst), .we(root_we), .wdata(root_wdata),
    .idle(idle), .root_q(root_q)
  );

  ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_idx (
    .vaddr(va_q), .lvl(lvl_q), .idx(cur_idx)
  );

  ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_addr (
    .base(base_q), .idx(cur_idx), .entry(mem_rsp_data),
    .entry_addr(entry_addr), .next_base(next_base), .entry_valid(entry_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      lvl_q         <= '0;
      base_q        <= '0;
      va_q          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_level     <= '0;
      rsp_paddr     <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          va_q   <= req_vaddr;
          base_q <= root_q;
          lvl_q  <= '0;
          state  <= S_ADDR;
        end
        S_ADDR: begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= entry_addr;
          state         <= S_REQ;
        end
        S_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state         <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          if (!entry_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_level <= lvl_q;
            rsp_paddr <= '0;
            state     <= S_RESP;
          end else if (lvl_q == LAST) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_level <= lvl_q;
            rsp_paddr <= {next_base[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
            state     <= S_RESP;
          end else begin
            base_q <= next_base;
            lvl_q  <= lvl_q + 1'b1;
            state  <= S_ADDR;
          end
        end
        S_RESP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: a pending read holds its address until taken
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R6: a returning entry never overlaps a new read request
  a_r6_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> !mem_req_valid);

  // R8: response held until consumed
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault)
      && $stable(rsp_paddr) && $stable(rsp_level));

  // R5: a fault carries no frame
  a_r5_fault_no_frame: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R9: no request or root write accepted while a result waits
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_req_valid) |-> !req_ready && !root_ready);

  // R3: level counter stays within the configured depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= LAST);
endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  localparam int L  = 3;
  localparam int I  = 3;
  localparam int O  = 6;
  localparam int P  = 15;
  localparam int VA = L * I + O;
  localparam int LW = $clog2(L);
  localparam int NW = 1 << (P - 3);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic root_we = 1'b0;
  logic [P-1:0] root_wdata = '0;
  logic root_ready;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA-1:0] req_vaddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic rsp_fault;
  logic [LW-1:0] rsp_level;
  logic [P-1:0] rsp_paddr;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [P-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  ptw_walker #(.LEVELS(L), .IDX_W(I), .OFF_W(O), .PA_W(P)) i_ptw_walker (
    .clk(clk), .rst(rst), .root_we(root_we), .root_wdata(root_wdata),
    .root_ready(root_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  logic [63:0] mem [NW];
  logic [P-1:0] got [16];
  int got_n = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [P-1:0] cur_root = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [I-1:0] fld(input logic [VA-1:0] va, input int k);
    return I'(va >> (O + (L - 1 - k) * I));
  endfunction

  task automatic model(input logic [VA-1:0] va, input logic [P-1:0] root,
                       output int n, output logic [P-1:0] ad [5],
                       output bit flt, output int lvl, output logic [P-1:0] pa);
    logic [P-1:0] base = root;
    logic [63:0] e;
    n = 0; flt = 0; lvl = L - 1; pa = '0;
    for (int i = 0; i < 5; i++) ad[i] = '0;
    for (int k = 0; k < L; k++) begin
      ad[k] = base + (P'(fld(va, k)) << 3);
      n++;
      e = mem[ad[k] >> 3];
      if (!e[0]) begin flt = 1; lvl = k; pa = '0; return; end
      if (k == L - 1) pa = {e[P-1:O], va[O-1:0]};
      else base = {e[P-1:O], {O{1'b0}}};
    end
  endtask

  // mark every entry on the path valid, optionally clear the one at level fk
  task automatic shape_path(input logic [VA-1:0] va, input logic [P-1:0] root,
                            input int fk);
    logic [P-1:0] base = root;
    logic [P-1:0] a;
    for (int k = 0; k < L; k++) begin
      a = base + (P'(fld(va, k)) << 3);
      mem[a >> 3][0] = (k != fk);
      if (k == fk) return;
      base = {mem[a >> 3][P-1:O], {O{1'b0}}};
    end
  endtask

  // memory model: random acceptance and latency, one read in flight
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [P-1:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[pa >> 3];
          pend = 0;
        end else lat--;
      end
      mem_req_ready = !pend && ($urandom % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin
        pa = mem_req_addr;
        if (got_n < 16) got[got_n] = mem_req_addr;
        got_n++;
        pend = 1;
        lat = $urandom % 4;
      end
    end
  end

  task automatic translate(input logic [VA-1:0] va, input string tag);
    int en, el, hold, cnt;
    bit ef, seen;
    logic [P-1:0] ead [5];
    logic [P-1:0] epa, p0;
    logic f0;
    logic [LW-1:0] l0;
    logic [P-1:0] acc_root;
    @(negedge clk);
    got_n = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    acc_root = cur_root;
    model(va, acc_root, en, ead, ef, el, epa);
    @(negedge clk);
    req_valid = 1'b0;
    hold = 1 + $urandom % 3;
    cnt = 0; seen = 0; p0 = '0; f0 = 0; l0 = '0;
    forever begin
      if (rsp_valid) begin
        if (!seen) begin p0 = rsp_paddr; f0 = rsp_fault; l0 = rsp_level; seen = 1; end
        cnt++;
        if (cnt >= hold) begin rsp_ready = 1'b1; break; end
      end
      @(negedge clk);
    end
    // R8: contents unchanged while rsp_ready was low
    chk(p0 == rsp_paddr && f0 == rsp_fault && l0 == rsp_level,
        {tag, " R8 hold"}, 64'(p0), 64'(rsp_paddr));
    // R4/R5: outcome
    chk(rsp_fault == ef, {tag, " R5 fault flag"}, 64'(rsp_fault), 64'(ef));
    chk(int'(rsp_level) == el, {tag, " R5 level"}, 64'(rsp_level), 64'(el));
    chk(rsp_paddr == epa, {tag, " R4 paddr"}, 64'(rsp_paddr), 64'(epa));
    // R3: read count and order (R2 covers the first)
    chk(got_n == en, {tag, " R3 read count"}, 64'(got_n), 64'(en));
    for (int k = 0; k < en && k < got_n; k++)
      chk(got[k] == ead[k], (k == 0) ? {tag, " R2 first addr"} : {tag, " R3 addr"},
          64'(got[k]), 64'(ead[k]));
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic write_root(input logic [P-1:0] v);
    @(negedge clk);
    root_we = 1'b1;
    root_wdata = v;
    forever begin
      #1;
      if (root_ready) break;
      @(negedge clk);
    end
    cur_root = v;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  function automatic logic [P-1:0] rand_page();
    return {P'($urandom)} & ~P'((1 << O) - 1);
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VA-1:0] va;
    void'($urandom(32'd4711));
    for (int i = 0; i < NW; i++) begin
      mem[i] = {$urandom, $urandom};
      mem[i][0] = ($urandom % 6) != 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R1 mem_req_valid", 64'(mem_req_valid), 0);
    chk(req_ready == 1, "R1 req_ready", 64'(req_ready), 1);
    chk(root_ready == 1, "R1 root_ready", 64'(root_ready), 1);
    // R1: root register is zero, seen through the first read address
    va = VA'($urandom);
    shape_path(va, '0, -1);
    translate(va, "R1 zero root");

    // R4: full successful walk from a written root
    write_root(rand_page());
    va = VA'($urandom);
    shape_path(va, cur_root, -1);
    translate(va, "R4 success");

    // R5: fault at the top and at the bottom level
    va = VA'($urandom);
    shape_path(va, cur_root, 0);
    translate(va, "R5 top fault");
    va = VA'($urandom);
    shape_path(va, cur_root, L - 1);
    translate(va, "R5 bottom fault");

    // R10: junk in unused entry bits changes nothing
    va = VA'($urandom);
    shape_path(va, cur_root, -1);
    for (int i = 0; i < NW; i++) begin
      mem[i][63:P] = ~mem[i][63:P];
      mem[i][O-1:1] = ~mem[i][O-1:1];
    end
    translate(va, "R10 junk bits");

    // R7: root write held during a walk lands only afterwards
    va = VA'($urandom);
    shape_path(va, cur_root, -1);
    fork
      translate(va, "R7 old root walk");
      begin
        logic [P-1:0] nr;
        nr = rand_page();
        repeat (3) @(negedge clk);
        root_we = 1'b1;
        root_wdata = nr;
        #1;
        chk(root_ready == 0, "R7 root_ready low while busy", 64'(root_ready), 0);
        chk(req_ready == 0, "R9 req_ready low while busy", 64'(req_ready), 0);
        forever begin
          #1;
          if (root_ready) break;
          @(negedge clk);
        end
        cur_root = nr;
        @(negedge clk);
        root_we = 1'b0;
      end
    join
    va = VA'($urandom);
    shape_path(va, cur_root, -1);
    translate(va, "R7 new root walk");

    // R9: root write and request in the same idle cycle
    va = VA'($urandom);
    fork
      begin
        logic [P-1:0] nr;
        nr = rand_page();
        shape_path(va, nr, -1);
        @(negedge clk);
        root_we = 1'b1;
        root_wdata = nr;
        cur_root = nr;
        #1;
        chk(req_ready == 0, "R9 root write first", 64'(req_ready), 0);
        @(negedge clk);
        root_we = 1'b0;
      end
      translate(va, "R9 request after root");
    join

    // random mix
    for (int t = 0; t < 150; t++) begin
      if ($urandom % 10 == 0) write_root(rand_page());
      va = VA'($urandom);
      if ($urandom % 4 == 0) shape_path(va, cur_root, -1);
      translate(va, "R3 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule